// File: doc/BRIEF.md
# Serial Command and Result Sequencer for a Multichannel Converter

This block is the digital slave side of a 16-bit multichannel converter that is driven by an external SPI clock in mode 0. Clock polarity is 0 and phase is 0. The serial clock, chip select and data-in pins are sampled into a faster system clock. An 8-bit command word is shifted in MSB first. Its fields are decoded into a channel number, a scan selector, a power-down selector and a clock-mode bit. The edges of the serial frame itself drive the conversion. One rising edge selects the channel and opens acquisition. A later falling edge ends acquisition and starts the conversion. Another falling edge loads the converter result, which then leaves on the data-out pin MSB first.

A framing input selects narrow (8-bit) or wide (16-bit) framing. In wide framing, the sample point and the result point both move eight clocks later, so acquisition is longer. The sample-and-hold and the successive-approximation core are not part of the block. A plain result bus with a valid flag stands in for them, and the block gives a sample strobe that marks the start of a conversion.

The frame state machine has these states: IDLE (deselected, shutdown), CMD (first command bits), ACQ (channel chosen, tracking), CONV (sampled, converting), XFER (result shifting out) and TAIL (zeros after the result). Its transitions are:
- IDLE to CMD on a chip-select fall.
- CMD to ACQ on rising edge 3.
- ACQ to CONV on falling edge 6 (narrow) or 14 (wide).
- CONV to XFER on falling edge 8 or 16.
- XFER to TAIL on the falling edge 16 clocks after the load.
- Any state to IDLE on a chip-select rise.

Top module: `adc_spi_seq`

## Requirements
- R1: After reset, `dout_oe`=0, `dout`=0, `shutdown`=1, `converting`=0, `chan_sel`=0, `scan_sel`=0, `int_clk`=0 and `pd_mode`=0. The command register resets to all zeros.
- R2: `dout_oe` is 0 while `cs_n` is high and 1 after `cs_n` falls. `dout` is 0 from the chip-select fall until the first result bit.
- R3: `din` is captured on SCLK rising edges 1 to 8 after the chip-select fall, MSB first. After edge 8, `scan_sel` shows command bits 4:3 and `int_clk` shows bit 0.
- R4: Exactly one `chan_stb` pulse is issued per frame, at rising edge 3. With it, `chan_sel` takes command bits 7:5. `chan_sel` changes at no other time.
- R5: Exactly one `sample_stb` pulse is issued, at falling edge 6 (narrow, `wide_frame`=0) or falling edge 14 (wide, `wide_frame`=1). `converting` is 1 from that pulse until the result is loaded.
- R6: At falling edge 8 (narrow) or 16 (wide), `res_data` is loaded. Its MSB appears on `dout`, and each later falling edge presents the next lower bit.
- R7: Falling edges after the 16 result bits, while `cs_n` stays low, present 0 on `dout`.
- R8: If `res_valid` is 0 at the load edge, all 16 result bits are presented as 0.
- R9: `pd_mode` takes command bits 2:1 only when `cs_n` rises. It stays unchanged while the frame is still selected.
- R10: A `cs_n` rise during a conversion clears `converting` at once and asserts `shutdown`.
- R11: A frame deselected before rising edge 8 leaves `scan_sel`, `int_clk` and the next `pd_mode` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCLK |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low chip select |
| din | input | 1 | Serial command data |
| wide_frame | input | 1 | 0 selects narrow framing, 1 selects wide framing |
| res_data | input | 16 | Result from the converter model |
| res_valid | input | 1 | Converter result is ready |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Output enable for dout (0 means high impedance) |
| chan_sel | output | 3 | Selected analog channel |
| chan_stb | output | 1 | One-cycle pulse: channel selected, acquisition begins |
| sample_stb | output | 1 | One-cycle pulse: acquisition ends, conversion starts |
| converting | output | 1 | Conversion in progress |
| scan_sel | output | 2 | Decoded scan field |
| int_clk | output | 1 | Decoded clock-mode bit |
| pd_mode | output | 2 | Power-down mode in force |
| shutdown | output | 1 | Block is deselected and shut down |

## Verification
Each pin change passes through two synchroniser stages and one edge flop. As a result, the strobes and the decoded fields are registered two system cycles after the first system edge that sees the pin. `dout` follows one cycle later, through the shift register.

The bench holds each SCLK phase for ten system cycles. It samples `dout` at the end of the low phase, just before it raises SCLK, so the previous falling edge has long settled. A monitor records the bench's own edge index at each strobe, so strobe positions are checked against edge numbers and not against cycle counts. The level checks after deselection wait a full half period as well.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CMD_W = 8;
    localparam int CH_W  = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ACQ,
        ST_CONV,
        ST_XFER,
        ST_TAIL
    } seq_state_t;

    // low five command bits, in their wire order
    typedef struct packed {
        logic [1:0] scan;
        logic [1:0] pwr;
        logic       clk_int;
    } cfg_t;

endpackage

// File: rtl/seq_sync.sv
module seq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level
);

    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= {STAGES{RST_VAL}};
        end else begin
            pipe <= {pipe[STAGES-2:0], pin};
        end
    end

    assign level = pipe[STAGES-1];

endmodule

// File: rtl/seq_out_shift.sv
module seq_out_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         load,
    input  logic         shift,
    input  logic         valid,
    input  logic [W-1:0] data,
    output logic         bit_out
);

    logic [W-1:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr <= '0;
        end else if (clear) begin
            sr <= '0;
        end else if (load) begin
            sr <= valid ? data : '0;
        end else if (shift) begin
            sr <= {sr[W-2:0], 1'b0};
        end
    end

    assign bit_out = sr[W-1];

endmodule

// File: rtl/seq_frame_fsm.sv
module seq_frame_fsm
    import adc_seq_pkg::*;
#(
    parameter int RES_W      = 16,
    parameter int WIDE_EXTRA = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_fall,
    input  logic            cs_rise,
    input  logic            sck_rise,
    input  logic            sck_fall,
    input  logic            din_lvl,
    input  logic            wide,
    output logic [CH_W-1:0] chan_sel,
    output logic            chan_stb,
    output logic            sample_stb,
    output logic            load_stb,
    output logic            shift_stb,
    output logic            clear_stb,
    output logic            converting,
    output logic [1:0]      scan_sel,
    output logic            int_clk,
    output logic [1:0]      pd_mode,
    output logic            shutdown
);

    localparam int LOAD_N      = CMD_W;
    localparam int LOAD_W      = CMD_W + WIDE_EXTRA;
    localparam int SAMPLE_LEAD = 2;
    localparam int CNT_W       = $clog2(LOAD_W + RES_W + 1) + 1;
    localparam int CFG_W       = $bits(cfg_t);
    localparam int SR_W        = CFG_W - 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    seq_state_t       state, nxt;
    logic [CNT_W-1:0] rise_cnt;
    logic [CNT_W-1:0] load_edge, sample_edge, tail_edge;
    logic [SR_W-1:0]  cmd_sr;
    cfg_t             cfg_q;
    logic             at_chan, at_cfg, at_sample, at_load, at_tail;

    assign load_edge   = wide ? CNT_W'(LOAD_W) : CNT_W'(LOAD_N);
    assign sample_edge = load_edge - CNT_W'(SAMPLE_LEAD);
    assign tail_edge   = load_edge + CNT_W'(RES_W);

    assign at_chan   = sck_rise && (rise_cnt == CNT_W'(CH_W - 1));
    assign at_cfg    = sck_rise && (rise_cnt == CNT_W'(CMD_W - 1));
    assign at_sample = sck_fall && (rise_cnt == sample_edge);
    assign at_load   = sck_fall && (rise_cnt == load_edge);
    assign at_tail   = sck_fall && (rise_cnt == tail_edge);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (cs_fall)  nxt = ST_CMD;
            ST_CMD:  if (cs_rise)  nxt = ST_IDLE;
                     else if (at_chan)   nxt = ST_ACQ;
            ST_ACQ:  if (cs_rise)  nxt = ST_IDLE;
                     else if (at_sample) nxt = ST_CONV;
            ST_CONV: if (cs_rise)  nxt = ST_IDLE;
                     else if (at_load)   nxt = ST_XFER;
            ST_XFER: if (cs_rise)  nxt = ST_IDLE;
                     else if (at_tail)   nxt = ST_TAIL;
            ST_TAIL: if (cs_rise)  nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_cnt   <= '0;
            cmd_sr     <= '0;
            cfg_q      <= '0;
            chan_sel   <= '0;
            chan_stb   <= 1'b0;
            sample_stb <= 1'b0;
            load_stb   <= 1'b0;
            shift_stb  <= 1'b0;
            clear_stb  <= 1'b0;
            converting <= 1'b0;
            pd_mode    <= '0;
            shutdown   <= 1'b1;
        end else begin
            chan_stb   <= (state == ST_CMD)  && at_chan;
            sample_stb <= (state == ST_ACQ)  && at_sample;
            load_stb   <= (state == ST_CONV) && at_load;
            shift_stb  <= ((state == ST_XFER) || (state == ST_TAIL)) && sck_fall;
            clear_stb  <= cs_rise;
            shutdown   <= (nxt == ST_IDLE);

            if (cs_fall) begin
                rise_cnt <= '0;
            end else if (sck_rise && (state != ST_IDLE) && (rise_cnt != CNT_MAX)) begin
                rise_cnt <= rise_cnt + CNT_W'(1);
            end

            if (sck_rise && (state != ST_IDLE) && (rise_cnt < CNT_W'(CMD_W))) begin
                cmd_sr <= {cmd_sr[SR_W-2:0], din_lvl};
            end

            if ((state == ST_CMD) && at_chan) begin
                chan_sel <= {cmd_sr[CH_W-2:0], din_lvl};
            end

            if ((state != ST_IDLE) && at_cfg) begin
                cfg_q <= cfg_t'({cmd_sr, din_lvl});
            end

            if (cs_rise) begin
                pd_mode <= cfg_q.pwr;
            end

            if (cs_rise || ((state == ST_CONV) && at_load)) begin
                converting <= 1'b0;
            end else if ((state == ST_ACQ) && at_sample) begin
                converting <= 1'b1;
            end
        end
    end

    assign scan_sel = cfg_q.scan;
    assign int_clk  = cfg_q.clk_int;

endmodule

// File: rtl/adc_spi_seq.sv
module adc_spi_seq
    import adc_seq_pkg::*;
#(
    parameter int RES_W       = 16,
    parameter int WIDE_EXTRA  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk,
    input  logic             cs_n,
    input  logic             din,
    input  logic             wide_frame,
    input  logic [RES_W-1:0] res_data,
    input  logic             res_valid,
    output logic             dout,
    output logic             dout_oe,
    output logic [CH_W-1:0]  chan_sel,
    output logic             chan_stb,
    output logic             sample_stb,
    output logic             converting,
    output logic [1:0]       scan_sel,
    output logic             int_clk,
    output logic [1:0]       pd_mode,
    output logic             shutdown
);

    localparam int         N_PINS   = 3;
    localparam logic [2:0] SYNC_RST = 3'b010;

    logic [N_PINS-1:0] pin_raw, pin_lvl;
    logic sck_lvl, cs_lvl, din_lvl;
    logic sck_prev, cs_prev;
    logic sck_rise, sck_fall, cs_rise, cs_fall;
    logic load_stb, shift_stb, clear_stb, sh_bit;

    assign pin_raw = {din, cs_n, sclk};

    for (genvar g = 0; g < N_PINS; g++) begin : g_sync
        seq_sync #(
            .STAGES (SYNC_STAGES),
            .RST_VAL(SYNC_RST[g])
        ) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (pin_raw[g]),
            .level(pin_lvl[g])
        );
    end

    assign sck_lvl = pin_lvl[0];
    assign cs_lvl  = pin_lvl[1];
    assign din_lvl = pin_lvl[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_prev  <= 1'b1;
            sck_prev <= 1'b0;
        end else begin
            cs_prev  <= cs_lvl;
            sck_prev <= sck_lvl;
        end
    end

    assign sck_rise =  sck_lvl & ~sck_prev;
    assign sck_fall = ~sck_lvl &  sck_prev;
    assign cs_rise  =  cs_lvl  & ~cs_prev;
    assign cs_fall  = ~cs_lvl  &  cs_prev;

    seq_frame_fsm #(
        .RES_W     (RES_W),
        .WIDE_EXTRA(WIDE_EXTRA)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .din_lvl   (din_lvl),
        .wide      (wide_frame),
        .chan_sel  (chan_sel),
        .chan_stb  (chan_stb),
        .sample_stb(sample_stb),
        .load_stb  (load_stb),
        .shift_stb (shift_stb),
        .clear_stb (clear_stb),
        .converting(converting),
        .scan_sel  (scan_sel),
        .int_clk   (int_clk),
        .pd_mode   (pd_mode),
        .shutdown  (shutdown)
    );

    seq_out_shift #(
        .W(RES_W)
    ) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clear_stb),
        .load   (load_stb),
        .shift  (shift_stb),
        .valid  (res_valid),
        .data   (res_data),
        .bit_out(sh_bit)
    );

    assign dout_oe = ~cs_lvl;
    assign dout    = dout_oe & sh_bit;

endmodule

// File: rtl/adc_spi_seq_chk.sv
module adc_spi_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       dout,
    input logic       dout_oe,
    input logic [2:0] chan_sel,
    input logic       chan_stb,
    input logic       sample_stb,
    input logic       converting,
    input logic [1:0] pd_mode,
    input logic       shutdown
);

    // R2: output leaves high impedance driving zero
    a_r2_quiet_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_oe) |-> !dout);

    // R4: channel changes only with its strobe
    a_r4_chan_only_on_stb: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(chan_sel) |-> chan_stb);

    // R4/R5: strobes come from opposite SCLK edges
    a_r4_stb_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({chan_stb, sample_stb}));

    // R5: sample strobe lasts a single cycle
    a_r5_sample_single: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> !sample_stb);

    // R5: conversion flag accompanies the sample strobe
    a_r5_sample_sets_conv: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> converting);

    // R9: power-down mode moves only on deselection
    a_r9_pd_at_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pd_mode) |-> $rose(shutdown));

    // R10: no conversion survives shutdown
    a_r10_no_conv_in_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |-> !converting);

endmodule

bind adc_spi_seq adc_spi_seq_chk u_chk (.*);

// File: tb/tb_adc_spi_seq.sv
`timescale 1ns/1ps
module tb_adc_spi_seq;

    localparam int HP = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        din = 1'b0;
    logic        wide_frame = 1'b0;
    logic [15:0] res_data = '0;
    logic        res_valid = 1'b0;
    logic        dout, dout_oe, chan_stb, sample_stb, converting, int_clk, shutdown;
    logic [2:0]  chan_sel;
    logic [1:0]  scan_sel, pd_mode;

    int n_checks = 0;
    int n_errs = 0;
    int rise_idx = 0, fall_idx = 0;
    int chan_hits = 0, samp_hits = 0, chan_at = 0, samp_at = 0;
    logic [2:0] chan_seen = '0;
    logic [1:0] cur_pd = '0, cur_scan = '0;
    logic       cur_int = 1'b0;
    bit         finished = 1'b0;

    always #2.5 clk = ~clk;

    adc_spi_seq dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
        .wide_frame(wide_frame), .res_data(res_data), .res_valid(res_valid),
        .dout(dout), .dout_oe(dout_oe), .chan_sel(chan_sel), .chan_stb(chan_stb),
        .sample_stb(sample_stb), .converting(converting), .scan_sel(scan_sel),
        .int_clk(int_clk), .pd_mode(pd_mode), .shutdown(shutdown)
    );

    always @(posedge clk) begin
        if (chan_stb) begin
            chan_hits = chan_hits + 1;
            chan_at   = rise_idx;
            chan_seen = chan_sel;
        end
        if (sample_stb) begin
            samp_hits = samp_hits + 1;
            samp_at   = fall_idx;
        end
    end

    task automatic chk(input int act, input int exp, input string req, input string what);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_bit(input int k, input bit w, input logic [15:0] r, input bit v);
        int idx;
        idx = k - 1 - (w ? 16 : 8);
        if (!v || idx < 0 || idx > 15) return 0;
        return int'(r[15-idx]);
    endfunction

    function automatic string bit_req(input int k, input bit w, input bit v);
        int idx;
        idx = k - 1 - (w ? 16 : 8);
        if (idx < 0)  return "R2";
        if (idx > 15) return "R7";
        if (!v)       return "R8";
        return "R6";
    endfunction

    task automatic frame(input logic [7:0] cmd, input bit w, input int nclk,
                         input logic [15:0] r, input bit v);
        int smp;
        res_data = r; res_valid = v; wide_frame = w;
        rise_idx = 0; fall_idx = 0; chan_hits = 0; samp_hits = 0;
        cs_n = 1'b0;
        repeat (HP) @(negedge clk);
        chk(dout_oe, 1, "R2", "dout_oe after select");
        for (int k = 1; k <= nclk; k++) begin
            din = (k <= 8) ? cmd[8-k] : 1'($urandom_range(0, 1));
            repeat (HP) @(negedge clk);
            chk(dout, exp_bit(k, w, r, v), bit_req(k, w, v), "dout before rising edge");
            sclk = 1'b1; rise_idx = k;
            repeat (HP) @(negedge clk);
            sclk = 1'b0; fall_idx = k;
        end
        repeat (HP) @(negedge clk);
        smp = w ? 14 : 6;
        if (nclk >= 3) begin
            chk(chan_hits, 1, "R4", "channel strobe count");
            chk(chan_at, 3, "R4", "channel strobe edge");
            chk(chan_seen, cmd[7:5], "R4", "channel value");
        end
        if (nclk >= smp) begin
            chk(samp_hits, 1, "R5", "sample strobe count");
            chk(samp_at, smp, "R5", "sample strobe edge");
        end else begin
            chk(samp_hits, 0, "R5", "no sample strobe yet");
        end
    endtask

    task automatic deselect();
        cs_n = 1'b1;
        repeat (HP) @(negedge clk);
        chk(dout_oe, 0, "R2", "dout_oe after deselect");
        chk(shutdown, 1, "R10", "shutdown after deselect");
        chk(converting, 0, "R10", "converting after deselect");
    endtask

    task automatic full_frame(input logic [7:0] cmd, input bit w, input int extra,
                              input logic [15:0] r, input bit v);
        frame(cmd, w, (w ? 32 : 24) + extra, r, v);
        chk(converting, 0, "R5", "conversion over after load");
        chk(scan_sel, cmd[4:3], "R3", "scan field");
        chk(int_clk, cmd[0], "R3", "clock-mode bit");
        chk(pd_mode, cur_pd, "R9", "pd_mode held while selected");
        deselect();
        cur_pd = cmd[2:1]; cur_scan = cmd[4:3]; cur_int = cmd[0];
        chk(pd_mode, cur_pd, "R9", "pd_mode after deselect");
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        chk(dout_oe, 0, "R1", "reset dout_oe");
        chk(dout, 0, "R1", "reset dout");
        chk(shutdown, 1, "R1", "reset shutdown");
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(converting, 0, "R1", "converting after reset");
        chk(chan_sel, 0, "R1", "chan_sel after reset");
        chk(scan_sel, 0, "R1", "scan_sel after reset");
        chk(int_clk, 0, "R1", "int_clk after reset");
        chk(pd_mode, 0, "R1", "pd_mode after reset");

        // directed frames: narrow, wide with tail, all ones, invalid result
        full_frame(8'b101_10_01_1, 1'b0, 0, 16'hA5C3, 1'b1);
        full_frame(8'b010_01_10_0, 1'b1, 4, 16'h8001, 1'b1);
        full_frame(8'b111_11_11_1, 1'b0, 6, 16'hFFFF, 1'b1);
        full_frame(8'b001_00_00_0, 1'b1, 0, 16'h1234, 1'b0);

        // R10/R11: abort mid conversion before command completes (narrow, 7 clocks)
        frame(8'b110_01_11_1, 1'b0, 7, 16'hFFFF, 1'b1);
        chk(converting, 1, "R10", "converting before abort");
        deselect();
        chk(scan_sel, cur_scan, "R11", "scan kept after early abort");
        chk(int_clk, cur_int, "R11", "int_clk kept after early abort");
        chk(pd_mode, cur_pd, "R11", "pd_mode kept after early abort");

        // R11: abort during acquisition
        frame(8'b011_11_10_1, 1'b0, 5, 16'h0F0F, 1'b1);
        chk(converting, 0, "R5", "no conversion before sample edge");
        deselect();
        chk(pd_mode, cur_pd, "R11", "pd_mode kept after acquisition abort");

        // R10: wide abort after command complete
        frame(8'b100_10_10_0, 1'b1, 15, 16'h7777, 1'b1);
        chk(converting, 1, "R10", "wide converting before abort");
        deselect();
        cur_pd = 2'b10; cur_scan = 2'b10; cur_int = 1'b0;
        chk(pd_mode, cur_pd, "R9", "pd_mode after wide abort");

        for (int i = 0; i < 20; i++) begin
            full_frame(8'($urandom), 1'($urandom_range(0, 1)), int'($urandom_range(0, 4)),
                       16'($urandom), ($urandom_range(0, 7) != 0));
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog run did not complete actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
            $finish;
        end
    end

endmodule